// File: doc/BRIEF.md
# Multithreaded Target Request/Response Agent

This agent sits in front of a simple target core. It takes requests from an initiator; each request carries a thread tag. Every thread has its own request queue. Requests on the same thread are answered strictly in the order they arrived. Requests on different threads may be answered in any order. A busy vector with one bit per thread tells the initiator which threads should not receive more requests. When one thread is saturated, the other threads keep flowing.

The target core is modelled as a word-addressed memory. Each thread has a programmable service latency, so that slow and fast threads can be mixed and responses can overtake each other across threads. When several threads hold an eligible request, a rotating pointer picks the one served next. At most one response leaves per clock. Each response carries a response code, read data and the thread tag of the request it answers. The response path has no backpressure: the initiator must accept a response in the cycle it appears.

Top module: `mt_target_agent`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `thread_busy`, `req_err` and `resp_valid` are 0, and `resp_code`, `resp_tid` and `resp_data` are 0.
- R2: A request with `req_valid` high, `req_tid` below THREADS and a target queue holding fewer than DEPTH entries at that edge is accepted. Every accepted request produces exactly one response.
- R3: `thread_busy[t]` is registered. It is 1 in the cycle after any edge that leaves thread t's queue holding DEPTH-1 or more entries, and 0 otherwise.
- R4: A request to a queue holding DEPTH entries, or with `req_tid` of THREADS or above, is not accepted. `req_err` is 1 for exactly the cycle after that edge.
- R5: Let thread t have latency L = `lat_cfg[t*LAT_W +: LAT_W]`, and let a request become the head of its queue at edge E (accepted into an empty queue, or its predecessor answered at E). That request is eligible from edge E+L. If it is granted at its first eligible edge, its response is visible after edge E+L+1.
- R6: Responses on one thread come out in the order the requests were accepted.
- R7: A request on a thread with a short latency may be answered before an earlier request on a thread with a longer latency.
- R8: If several threads are eligible at an edge, the one served is the first eligible thread found when searching upward (with wrap-around) from a pointer. The pointer is 0 after reset, and after each grant to thread g it moves to g+1, modulo THREADS.
- R9: A write (`req_cmd`=1) stores `req_wdata` into word `req_addr[MEM_AW-1:0]`. Its response has `resp_code`=2'b01 (DVA) and `resp_data`=0.
- R10: A read (`req_cmd`=0) returns `resp_code`=2'b01 (DVA), with `resp_data` equal to that word as left by all writes answered earlier.
- R11: A response has `resp_valid`=1 for one cycle, and `resp_tid` equal to the request's tag. In cycles without a response, the code, tag and data outputs are 0.
- R12: A thread that is busy or full never delays eligible requests on other threads. Whenever any thread is eligible, a response is produced at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_cmd | input | 1 | 0 = read, 1 = write |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write data |
| req_tid | input | 4 | Request thread tag |
| lat_cfg | input | THREADS*LAT_W | Per-thread service latency, thread t in bits [t*LAT_W +: LAT_W] |
| thread_busy | output | THREADS | Per-thread busy flags |
| req_err | output | 1 | Rejected request flag, one cycle after the rejected request |
| resp_valid | output | 1 | Response present this cycle |
| resp_code | output | 2 | 2'b00 idle, 2'b01 DVA |
| resp_tid | output | 4 | Thread tag of the response |
| resp_data | output | DW | Read data, 0 for writes |

## Verification
The bench builds the agent with THREADS=4, DEPTH=4, LAT_W=4, AW=16, DW=32 and MEM_AW=4. With four threads, tags 4 to 15 are out of range, so the out-of-range rejection can be driven without changing the tag width. A depth of four makes the busy threshold (three entries) and the full-queue rejection (four entries) reachable within a handful of back-to-back requests. Latencies of up to 15 cycles let one thread hold a request while the other threads overtake it. They also let several threads be parked and then released together, which exercises the rotating pointer from different starting positions.

// File: rtl/mtta_pkg.sv
package mtta_pkg;
  typedef enum logic {CMD_RD = 1'b0, CMD_WR = 1'b1} cmd_e;
  typedef enum logic [1:0] {RC_NULL = 2'b00, RC_DVA = 2'b01} rcode_e;
endpackage

// File: rtl/thread_lane.sv
module thread_lane #(
  parameter int DEPTH = 4,
  parameter int EW    = 49,
  parameter int LAT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [EW-1:0]    push_data,
  input  logic             pop,
  input  logic [LAT_W-1:0] lat,
  output logic [EW-1:0]    head,
  output logic             ready,
  output logic             full,
  output logic             busy
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_AT = CW'(DEPTH);
  localparam logic [CW-1:0] BUSY_AT = CW'(DEPTH - 1);

  logic [EW-1:0]    slot_q [DEPTH];
  logic [PW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [LAT_W-1:0] wait_q;
  logic             busy_q;

  // storage without reset so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (push) slot_q[wr_ptr_q] <= push_data;
  end

  assign head  = slot_q[rd_ptr_q];
  assign full  = (cnt_q == FULL_AT);
  assign ready = (cnt_q != '0) && (wait_q >= lat);
  assign busy  = busy_q;

  always_comb begin
    cnt_d = cnt_q;
    if (push && !pop) cnt_d = cnt_q + 1'b1;
    else if (pop && !push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      wait_q   <= '0;
      busy_q   <= 1'b0;
    end else begin
      if (push) wr_ptr_q <= (wr_ptr_q == PW'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
      if (pop)  rd_ptr_q <= (rd_ptr_q == PW'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
      cnt_q  <= cnt_d;
      busy_q <= (cnt_d >= BUSY_AT);
      if (pop || cnt_q == '0) wait_q <= '0;
      else if (wait_q < lat)  wait_q <= wait_q + 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) push |-> !full); // R4
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst) pop |-> cnt_q != '0); // R6
  AST_POP_ELIGIBLE: assert property (@(posedge clk) disable iff (rst) pop |-> ready); // R5
  AST_BUSY_WHEN_FULL: assert property (@(posedge clk) disable iff (rst) full |-> busy_q); // R3
endmodule

// File: rtl/rr_arbiter.sv
module rr_arbiter #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] gnt_idx,
  output logic          any
);
  logic [IW-1:0] ptr_q;

  always_comb begin
    any     = 1'b0;
    gnt_idx = '0;
    for (int i = 0; i < N; i++) begin
      int j;
      j = int'(ptr_q) + i;
      if (j >= N) j = j - N;
      if (!any && req[j]) begin
        any     = 1'b1;
        gnt_idx = IW'(j);
      end
    end
    for (int k = 0; k < N; k++) grant[k] = any && (gnt_idx == IW'(k));
  end

  always_ff @(posedge clk) begin
    if (rst) ptr_q <= '0;
    else if (any) ptr_q <= (gnt_idx == IW'(N - 1)) ? '0 : gnt_idx + 1'b1;
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot0(grant)); // R8
  AST_GRANT_SUBSET: assert property (@(posedge clk) disable iff (rst) (grant & ~req) == '0); // R8
  AST_WORK_CONSERVE: assert property (@(posedge clk) disable iff (rst) (|req) |-> (|grant)); // R12
endmodule

// File: rtl/target_core.sv
module target_core
  import mtta_pkg::*;
#(
  parameter int DW     = 32,
  parameter int MEM_AW = 4,
  parameter int TID_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              cmd,
  input  logic [MEM_AW-1:0] idx,
  input  logic [DW-1:0]     wdata,
  input  logic [TID_W-1:0]  tid,
  output logic              resp_valid,
  output logic [1:0]        resp_code,
  output logic [TID_W-1:0]  resp_tid,
  output logic [DW-1:0]     resp_data
);
  localparam int WORDS = 1 << MEM_AW;

  logic [DW-1:0] mem_q [WORDS];

  always_ff @(posedge clk) begin
    if (go && cmd == CMD_WR) mem_q[idx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || !go) begin
      resp_valid <= 1'b0;
      resp_code  <= RC_NULL;
      resp_tid   <= '0;
      resp_data  <= '0;
    end else begin
      resp_valid <= 1'b1;
      resp_code  <= RC_DVA;
      resp_tid   <= tid;
      resp_data  <= (cmd == CMD_WR) ? '0 : mem_q[idx];
    end
  end

  AST_WRITE_ACK: assert property (@(posedge clk) disable iff (rst) (go && cmd == CMD_WR) |=> (resp_valid && resp_code == RC_DVA && resp_data == '0)); // R9
  AST_ONE_RESP_PER_GO: assert property (@(posedge clk) disable iff (rst) resp_valid |-> $past(go)); // R11
endmodule

// File: rtl/mt_target_agent.sv
module mt_target_agent
  import mtta_pkg::*;
#(
  parameter int THREADS = 4,
  parameter int DEPTH   = 4,
  parameter int LAT_W   = 4,
  parameter int AW      = 16,
  parameter int DW      = 32,
  parameter int MEM_AW  = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  input  logic                     req_cmd,
  input  logic [AW-1:0]            req_addr,
  input  logic [DW-1:0]            req_wdata,
  input  logic [3:0]               req_tid,
  input  logic [THREADS*LAT_W-1:0] lat_cfg,
  output logic [THREADS-1:0]       thread_busy,
  output logic                     req_err,
  output logic                     resp_valid,
  output logic [1:0]               resp_code,
  output logic [3:0]               resp_tid,
  output logic [DW-1:0]            resp_data
);
  localparam int TID_W = 4;
  localparam int IW    = (THREADS > 1) ? $clog2(THREADS) : 1;
  localparam int EW    = 1 + AW + DW;
  localparam logic [TID_W:0] NTH = (TID_W + 1)'(THREADS);

  logic              in_range, hit_full, err_q;
  logic [THREADS-1:0] push_v, ready_v, full_v, grant_v;
  logic [EW-1:0]     head_v [THREADS];
  logic [EW-1:0]     sel;
  logic [IW-1:0]     gnt_idx;
  logic              gnt_any;

  assign in_range = ({1'b0, req_tid} < NTH);

  always_comb begin
    hit_full = 1'b0;
    for (int t = 0; t < THREADS; t++)
      if (req_tid == TID_W'(t) && full_v[t]) hit_full = 1'b1;
  end

  for (genvar t = 0; t < THREADS; t++) begin : g_lane
    assign push_v[t] = req_valid && in_range && req_tid == TID_W'(t) && !full_v[t];
    thread_lane #(.DEPTH(DEPTH), .EW(EW), .LAT_W(LAT_W)) u_lane (
      .clk      (clk),
      .rst      (rst),
      .push     (push_v[t]),
      .push_data({req_cmd, req_addr, req_wdata}),
      .pop      (grant_v[t]),
      .lat      (lat_cfg[t*LAT_W +: LAT_W]),
      .head     (head_v[t]),
      .ready    (ready_v[t]),
      .full     (full_v[t]),
      .busy     (thread_busy[t])
    );
  end

  rr_arbiter #(.N(THREADS), .IW(IW)) u_arb (
    .clk    (clk),
    .rst    (rst),
    .req    (ready_v),
    .grant  (grant_v),
    .gnt_idx(gnt_idx),
    .any    (gnt_any)
  );

  assign sel = head_v[gnt_idx];

  target_core #(.DW(DW), .MEM_AW(MEM_AW), .TID_W(TID_W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .go        (gnt_any),
    .cmd       (sel[EW-1]),
    .idx       (sel[DW +: MEM_AW]),
    .wdata     (sel[DW-1:0]),
    .tid       (TID_W'(gnt_idx)),
    .resp_valid(resp_valid),
    .resp_code (resp_code),
    .resp_tid  (resp_tid),
    .resp_data (resp_data)
  );

  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else     err_q <= req_valid && (!in_range || hit_full);
  end
  assign req_err = err_q;

  AST_ERR_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst) req_err |-> $past(req_valid)); // R4
  AST_TID_RANGE: assert property (@(posedge clk) disable iff (rst) resp_valid |-> ({1'b0, resp_tid} < NTH)); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) !resp_valid |-> (resp_code == RC_NULL && resp_data == '0)); // R11
endmodule

// File: tb/mt_target_agent_test.sv
module mt_target_agent_test;
  localparam int N = 4, D = 4, LW = 4, AW = 16, DW = 32, MAW = 4;

  typedef struct { bit wr; int addr; logic [DW-1:0] d; } ent_t;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_cmd = 0;
  logic [AW-1:0] req_addr = 0;
  logic [DW-1:0] req_wdata = 0;
  logic [3:0] req_tid = 0;
  logic [LW-1:0] lat_v [N];
  logic [N*LW-1:0] lat_cfg;
  logic [N-1:0] thread_busy;
  logic req_err, resp_valid;
  logic [1:0] resp_code;
  logic [3:0] resp_tid;
  logic [DW-1:0] resp_data;

  assign lat_cfg = {lat_v[3], lat_v[2], lat_v[1], lat_v[0]};

  mt_target_agent #(.THREADS(N), .DEPTH(D), .LAT_W(LW), .AW(AW), .DW(DW), .MEM_AW(MAW)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_cmd(req_cmd), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_tid(req_tid), .lat_cfg(lat_cfg), .thread_busy(thread_busy),
    .req_err(req_err), .resp_valid(resp_valid), .resp_code(resp_code), .resp_tid(resp_tid),
    .resp_data(resp_data));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  // reference model state
  ent_t q [N][$];
  int tmr [N];
  int ptr = 0, accepted = 0, seen = 0;
  logic [DW-1:0] mm [16];
  logic [N-1:0] e_busy = 0;
  logic e_err = 0, e_valid = 0;
  logic [1:0] e_code = 0;
  logic [3:0] e_tid = 0;
  logic [DW-1:0] e_data = 0;

  int first_seen [N];
  logic [DW-1:0] last_rd0;

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      for (int t = 0; t < N; t++) begin q[t].delete(); tmr[t] = 0; end
      ptr = 0; e_busy = 0; e_err = 0; e_valid = 0; e_code = 0; e_tid = 0; e_data = 0;
    end else begin
      int g;
      int tn [N];
      bit do_push;
      g = -1;
      for (int i = 0; i < N; i++) begin
        int j;
        j = (ptr + i) % N;
        if (g < 0 && q[j].size() > 0 && tmr[j] >= int'(lat_v[j])) g = j;
      end
      for (int t = 0; t < N; t++) begin
        if (t == g || q[t].size() == 0) tn[t] = 0;
        else if (tmr[t] < int'(lat_v[t])) tn[t] = tmr[t] + 1;
        else tn[t] = tmr[t];
      end
      do_push = 0; e_err = 0;
      if (req_valid) begin
        if (int'(req_tid) < N && q[req_tid].size() < D) do_push = 1;
        else e_err = 1;
      end
      if (g >= 0) begin
        ent_t e;
        e = q[g].pop_front();
        e_valid = 1; e_code = 2'b01; e_tid = 4'(g);
        if (e.wr) begin mm[e.addr] = e.d; e_data = 0; end
        else e_data = mm[e.addr];
        ptr = (g + 1) % N;
      end else begin
        e_valid = 0; e_code = 0; e_tid = 0; e_data = 0;
      end
      if (do_push) begin
        ent_t n;
        n.wr = req_cmd; n.addr = int'(req_addr[MAW-1:0]); n.d = req_wdata;
        q[req_tid].push_back(n);
        accepted++;
      end
      for (int t = 0; t < N; t++) begin
        tmr[t] = tn[t];
        e_busy[t] = (q[t].size() >= D - 1);
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R3/R12 thread_busy", DW'(thread_busy), DW'(e_busy));
      chk("R4 req_err", DW'(req_err), DW'(e_err));
      chk("R5 resp_valid", DW'(resp_valid), DW'(e_valid));
      chk("R8/R11 resp_tid", DW'(resp_tid), DW'(e_tid));
      chk("R9 resp_code", DW'(resp_code), DW'(e_code));
      chk("R6/R10 resp_data", resp_data, e_data);
      if (resp_valid) begin
        seen++;
        if (resp_tid < 4'(N) && first_seen[resp_tid] < 0) first_seen[resp_tid] = cyc;
        if (resp_tid == 0) last_rd0 = resp_data;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<=20000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic issue(input int tid, input bit wr, input int addr, input logic [DW-1:0] d);
    req_valid = 1; req_tid = 4'(tid); req_cmd = wr; req_addr = AW'(addr); req_wdata = d;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_seen();
    for (int t = 0; t < N; t++) first_seen[t] = -1;
  endtask

  initial begin
    for (int t = 0; t < N; t++) begin lat_v[t] = 0; first_seen[t] = -1; end
    for (int a = 0; a < 16; a++) mm[a] = 0;
    last_rd0 = 0;
    repeat (3) @(negedge clk);
    // R1: reset values, held while reset is high
    chk("R1 busy in reset", DW'(thread_busy), 0);
    chk("R1 resp_valid in reset", DW'(resp_valid), 0);
    chk("R1 req_err in reset", DW'(req_err), 0);
    rst = 0;
    @(negedge clk);
    chk("R1 resp_data after reset", resp_data, 0);

    // fill all memory words through thread 0 and thread 1
    for (int a = 0; a < 16; a++) issue(a % 2, 1, a, 32'hA500_0000 + DW'(a * 17));
    idle(4);
    // read back on several threads
    for (int a = 0; a < 16; a++) issue(a % 4, 0, 15 - a, 0);
    idle(4);

    // R6: write, overwrite and read on one slow thread stay in order
    lat_v[0] = 3;
    issue(0, 1, 7, 32'h1111_1111);
    issue(0, 1, 7, 32'h2222_2222);
    issue(0, 0, 7, 0);
    idle(20);
    chk("R6 last read on thread 0", last_rd0, 32'h2222_2222);

    // R7: slow thread 0, fast thread 1: later request overtakes
    lat_v[0] = 6; lat_v[1] = 0;
    clear_seen();
    issue(0, 0, 3, 0);
    issue(1, 0, 5, 0);
    idle(15);
    chk("R7 thread 1 answered first", DW'(first_seen[1] < first_seen[0]), 1);

    // R3/R4/R12: saturate thread 2 while thread 3 keeps flowing
    lat_v[2] = 8; lat_v[3] = 0;
    clear_seen();
    for (int k = 0; k < 5; k++) issue(2, 1, 8 + k, 32'hC0DE_0000 + DW'(k));
    issue(3, 0, 9, 0);
    issue(3, 0, 2, 0);
    idle(2);
    chk("R12 thread 3 served while thread 2 full", DW'(first_seen[3] >= 0 && first_seen[2] < 0), 1);
    idle(60);

    // R4: out-of-range tags rejected
    issue(9, 1, 0, 32'hDEAD_BEEF);
    issue(15, 0, 0, 0);
    idle(3);

    // R8: park requests on all threads, then release together
    for (int t = 0; t < N; t++) lat_v[t] = 15;
    issue(3, 0, 1, 0);
    issue(1, 1, 4, 32'h4444_0001);
    issue(0, 0, 4, 0);
    issue(2, 0, 6, 0);
    issue(1, 0, 4, 0);
    issue(3, 1, 6, 32'h6666_0003);
    idle(2);
    for (int t = 0; t < N; t++) lat_v[t] = 0;
    idle(12);
    // second release from a different pointer position
    for (int t = 0; t < N; t++) lat_v[t] = 9;
    issue(2, 0, 6, 0);
    issue(0, 1, 6, 32'h7777_0000);
    issue(1, 0, 6, 0);
    idle(3);
    for (int t = 0; t < N; t++) lat_v[t] = 1;
    idle(12);

    // R2: every accepted request answered exactly once
    chk("R2 responses equal accepted requests", DW'(seen), DW'(accepted));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule